// File: doc/BRIEF.md
# Context-Switch Cache Flush Sequencer

This block orders the maintenance work that a virtually addressed split level-one cache needs whenever the running process changes. One start pulse launches a fixed chain of request/done handshakes. The chain can clean the data cache, then it invalidates the data cache, invalidates the instruction cache, drains the write buffer and invalidates the TLB. The TLB takes part because virtual lookups draw their page permissions from it. Each step raises its request and holds it until the addressed unit answers with done. Only then does the next step begin. The cache arrays, the write buffer and the TLB sit outside the block.

A configuration input says whether the data cache is write-back. In write-through mode there are no dirty lines to write back, so the clean step is left out. The whole chain runs on every process switch. Its length in cycles is captured so that the cost of each switch can be measured. A busy flag covers the sequence and a one-cycle pulse marks its end.

Top module: `ctxsw_flush_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, busy, complete and all step requests are low and the measured length is zero.
- R2: A start pulse seen while idle sets busy in the next cycle. In that same cycle the request of the first step rises. The first step is bit 0 when the write-back input is 1 and bit 1 when it is 0.
- R3: Requests run in bit order on the step vector, each step issued exactly once. The bits are: bit 0 cleans the data cache, bit 1 invalidates the data cache, bit 2 invalidates the instruction cache, bit 3 drains the write buffer and bit 4 invalidates the TLB.
- R4: At most one request is high at a time. A request stays high until done of the same bit is seen, and the next request rises in the following cycle.
- R5: With the write-back input at 0 when start is taken, bit 0 is never requested during that sequence.
- R6: The write-back input is sampled only when start is taken. Changing it during a sequence does not alter which steps run.
- R7: A start pulse that arrives while busy has no effect. The sequence in progress keeps its order and length, and there is no extra completion.
- R8: Complete is high for exactly one cycle, the cycle after done of bit 4, and busy is already low in that cycle.
- R9: The length output equals the number of cycles busy was high in the most recent sequence. It updates together with complete and holds its value at all other times, including during the next sequence.
- R10: A done on any bit other than the step in progress is ignored. The request in progress stays high and the sequence length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Context-switch trigger pulse |
| wb_cfg_i | input | 1 | 1 = data cache is write-back (clean step included) |
| step_done_i | input | 5 | Done per step, same bit layout as the requests |
| step_req_o | output | 5 | Request per step (bit 0 clean, 1 D-inv, 2 I-inv, 3 drain, 4 TLB) |
| busy_o | output | 1 | High while a sequence is running |
| complete_o | output | 1 | One-cycle pulse after the last step finishes |
| seq_cycles_o | output | CNT_W | Busy length of the latest sequence in cycles |

## Verification
The chain is driven by responders whose latency is set per step. The patterns include all-zero latency, a mixed latency profile, a maximum-latency profile and uneven profiles in both cache modes. This separates ordering faults from counting faults: a shifted count appears only when the latencies differ between steps. Pairing each latency profile with both modes shows whether the clean step is skipped, and whether the skip is charged correctly in the length. Directed runs add the disturbances a correct sequencer must ignore: a second start, a mode flip partway through and done pulses on idle steps.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  localparam int unsigned NUM_STEPS = 5;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  typedef logic [STEP_W-1:0] step_t;

  // Step identifiers; the numeric value is also the request bit position.
  localparam step_t STEP_CLEAN = step_t'(0);
  localparam step_t STEP_DINV  = step_t'(1);
  localparam step_t STEP_IINV  = step_t'(2);
  localparam step_t STEP_DRAIN = step_t'(3);
  localparam step_t STEP_TLB   = step_t'(4);

  // Entry point of the chain: the clean step exists only for write-back.
  function automatic step_t first_step(input logic write_back);
    return write_back ? STEP_CLEAN : STEP_DINV;
  endfunction

  function automatic logic is_final(input step_t s);
    return s == STEP_TLB;
  endfunction

  function automatic step_t next_step(input step_t s);
    return s + step_t'(1);
  endfunction

endpackage

// File: rtl/ctxsw_step_ctrl.sv
module ctxsw_step_ctrl
  import ctxsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  wb_cfg_i,
  input  logic  hit_i,
  output logic  active_o,
  output step_t cur_o,
  output logic  wb_lat_o,
  output logic  accept_o,
  output logic  finish_o,
  output logic  complete_o
);

  logic  active_q;
  step_t cur_q;
  logic  wb_q;
  logic  complete_q;

  assign accept_o   = start_i && !active_q;
  assign finish_o   = active_q && hit_i && is_final(cur_q);
  assign active_o   = active_q;
  assign cur_o      = cur_q;
  assign wb_lat_o   = wb_q;
  assign complete_o = complete_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      cur_q      <= STEP_CLEAN;
      wb_q       <= 1'b0;
      complete_q <= 1'b0;
    end else begin
      complete_q <= 1'b0;
      if (accept_o) begin
        active_q <= 1'b1;
        cur_q    <= first_step(wb_cfg_i);
        wb_q     <= wb_cfg_i;
      end else if (active_q && hit_i) begin
        if (is_final(cur_q)) begin
          active_q   <= 1'b0;
          complete_q <= 1'b1;
        end else begin
          cur_q <= next_step(cur_q);
        end
      end
    end
  end

  // R2: an accepted start makes the block busy on the next cycle
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_q) |=> active_q);

  // R4 / R7: without a hit the step in progress is kept, whatever start does
  assert_hold_without_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !hit_i) |=> (active_q && cur_q == $past(cur_q)));

  // R6: latched mode is frozen for the whole sequence
  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> $stable(wb_q));

  // R8: completion is a single-cycle pulse seen while idle
  assert_complete_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    complete_q |=> !complete_q);
  assert_complete_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    complete_q |-> !active_q);

endmodule

// File: rtl/ctxsw_req_lanes.sv
module ctxsw_req_lanes
  import ctxsw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active_i,
  input  step_t                cur_i,
  input  logic [NUM_STEPS-1:0] done_i,
  output logic [NUM_STEPS-1:0] req_o,
  output logic                 hit_o
);

  logic [NUM_STEPS-1:0] lane_hit;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_lane
    assign req_o[g]    = active_i && (cur_i == step_t'(g));
    assign lane_hit[g] = req_o[g] && done_i[g];

    // R4: a lane keeps requesting until its own done arrives
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o[g] && !done_i[g]) |=> req_o[g]);
  end

  // R10: only the lane in progress can produce a hit
  assign hit_o = |lane_hit;

  // R4: steps never overlap
  assert_single_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_o));

endmodule

// File: rtl/ctxsw_cycle_meter.sv
module ctxsw_cycle_meter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             busy_i,
  input  logic             finish_i,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] len_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      len_q <= '0;
    end else begin
      if (clear_i)     run_q <= '0;
      else if (busy_i) run_q <= sat_inc(run_q);
      if (finish_i)    len_q <= sat_inc(run_q);
    end
  end

  assign len_o = len_q;

  // R9: the reported length only moves at the end of a sequence
  assert_len_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_i |=> $stable(len_q));

endmodule

// File: rtl/ctxsw_flush_seq.sv
module ctxsw_flush_seq
  import ctxsw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 wb_cfg_i,
  input  logic [NUM_STEPS-1:0] step_done_i,
  output logic [NUM_STEPS-1:0] step_req_o,
  output logic                 busy_o,
  output logic                 complete_o,
  output logic [CNT_W-1:0]     seq_cycles_o
);

  // Named internal events, visible to assertions
  logic  seq_active;
  step_t seq_step;
  logic  seq_wb;
  logic  seq_accept;
  logic  seq_finish;
  logic  step_hit;

  ctxsw_step_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wb_cfg_i   (wb_cfg_i),
    .hit_i      (step_hit),
    .active_o   (seq_active),
    .cur_o      (seq_step),
    .wb_lat_o   (seq_wb),
    .accept_o   (seq_accept),
    .finish_o   (seq_finish),
    .complete_o (complete_o)
  );

  ctxsw_req_lanes u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (seq_active),
    .cur_i    (seq_step),
    .done_i   (step_done_i),
    .req_o    (step_req_o),
    .hit_o    (step_hit)
  );

  ctxsw_cycle_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (seq_accept),
    .busy_i   (seq_active),
    .finish_i (seq_finish),
    .len_o    (seq_cycles_o)
  );

  assign busy_o = seq_active;

  // R5: no clean request in a write-through sequence
  assert_no_clean_wt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !seq_wb) |-> !step_req_o[0]);

  // R8: completion follows the final TLB handshake
  assert_complete_after_tlb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req_o[4] && step_done_i[4]) |=> complete_o);

  // R1 / R4: requests only while busy
  assert_req_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (step_req_o == '0));

endmodule

// File: tb/ctxsw_flush_seq_tb.sv
module ctxsw_flush_seq_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             wb_cfg = 1'b0;
  logic [4:0]       done;
  logic [4:0]       stray = '0;
  logic [4:0]       req;
  logic             busy;
  logic             complete;
  logic [CNT_W-1:0] seq_cycles;

  int n_chk = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  logic [3:0] lat [5];
  logic [4:0] rcnt [5];

  always #4ns clk = ~clk;   // 125 MHz

  ctxsw_flush_seq #(.CNT_W(CNT_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .wb_cfg_i     (wb_cfg),
    .step_done_i  (done),
    .step_req_o   (req),
    .busy_o       (busy),
    .complete_o   (complete),
    .seq_cycles_o (seq_cycles)
  );

  // Responders: answer done after lat[i] further cycles of request
  always_ff @(posedge clk) begin
    for (int i = 0; i < 5; i++) rcnt[i] <= req[i] ? rcnt[i] + 5'd1 : 5'd0;
  end
  always_comb begin
    for (int i = 0; i < 5; i++)
      done[i] = (req[i] && rcnt[i] == {1'b0, lat[i]}) || stray[i];
  end

  // Vector: {wb, lat4, lat3, lat2, lat1, lat0}
  localparam logic [20:0] VECS [6] = '{
    {1'b1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {1'b1, 4'd5, 4'd0, 4'd2, 4'd1, 4'd3},
    {1'b0, 4'd2, 4'd7, 4'd0, 4'd4, 4'd9},
    {1'b1, 4'd15, 4'd15, 4'd15, 4'd15, 4'd15},
    {1'b0, 4'd4, 4'd3, 4'd2, 4'd1, 4'd6}
  };

  function automatic int exp_len(input logic [20:0] v);
    int s = 0;
    for (int i = (v[20] ? 0 : 1); i < 5; i++) s += int'(v[4*i +: 4]) + 1;
    return s;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [20:0] v, input int mid_start,
                         input int flip_at, input int stray_at);
    logic wbm;
    int rises [5];
    int order [8];
    int n_ord, busy_n, comp_n, cyc, exp, first_lane;
    logic [4:0] prev_req, stray_ref;
    logic [CNT_W-1:0] old_len;
    wbm = v[20];
    for (int i = 0; i < 5; i++) begin lat[i] = v[4*i +: 4]; rises[i] = 0; end
    for (int k = 0; k < 8; k++) order[k] = -1;
    exp = exp_len(v);
    first_lane = wbm ? 0 : 1;
    n_ord = 0; busy_n = 0; comp_n = 0; cyc = 0;
    prev_req = '0; stray_ref = '0;
    @(negedge clk);
    old_len = seq_cycles;
    wb_cfg = wbm;
    start = 1'b1;
    while (comp_n == 0 && cyc < 400) begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < 5; i++) begin
        if (req[i] && !prev_req[i]) begin
          rises[i]++;
          if (n_ord < 8) order[n_ord] = i;
          n_ord++;
        end
      end
      chk($countones(req) <= 1, "R4 single request", $countones(req), 1);
      if (busy) busy_n++;
      if (complete) begin
        comp_n++;
        chk(!busy, "R8 busy low at complete", int'(busy), 0);
      end
      if (cyc == 1) begin
        chk(busy, "R2 busy after start", int'(busy), 1);
        chk(req == (5'b1 << first_lane), "R2 first request", int'(req), 1 << first_lane);
        chk(seq_cycles == old_len, "R9 length held while running", int'(seq_cycles), int'(old_len));
      end
      if (stray_at > 0 && cyc == stray_at + 1)
        chk(req == stray_ref, "R10 stray done ignored", int'(req), int'(stray_ref));
      prev_req = req;
      start = (cyc == mid_start);
      if (cyc == flip_at) wb_cfg = ~wbm;
      if (cyc == stray_at) begin stray = ~req; stray_ref = req; end
      else stray = '0;
    end
    start = 1'b0; stray = '0; wb_cfg = wbm;
    chk(comp_n == 1, "R8 one completion", comp_n, 1);
    chk(busy_n == exp, "R9 busy cycles", busy_n, exp);
    chk(int'(seq_cycles) == exp, "R9 measured length", int'(seq_cycles), exp);
    chk(rises[0] == (wbm ? 1 : 0), "R5 clean step issue", rises[0], wbm ? 1 : 0);
    for (int i = 1; i < 5; i++)
      chk(rises[i] == 1, "R3 step issued once", rises[i], 1);
    chk(n_ord == 5 - first_lane, "R3 step count", n_ord, 5 - first_lane);
    for (int k = 0; k < 5 - first_lane; k++)
      chk(order[k] == first_lane + k, "R3 step order", order[k], first_lane + k);
    @(negedge clk);
    chk(!complete, "R8 complete one cycle", int'(complete), 0);
    chk(int'(seq_cycles) == exp, "R9 length held after", int'(seq_cycles), exp);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) lat[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && req == '0 && !complete, "R1 outputs in reset", int'({busy, req, complete}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req == '0 && !complete, "R1 outputs after reset", int'({busy, req, complete}), 0);
    chk(seq_cycles == '0, "R1 length after reset", int'(seq_cycles), 0);

    // Table of latency profiles in both modes (R2, R3, R4, R5, R8, R9)
    for (int t = 0; t < 6; t++) run_seq(VECS[t], 0, 0, 0);

    // R7: second start while busy
    run_seq({1'b1, 4'd1, 4'd2, 4'd3, 4'd2, 4'd1}, 3, 0, 0);
    // R6: mode raised to write-back partway through a write-through run
    run_seq({1'b0, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1}, 0, 2, 0);
    // R6: mode dropped partway through a write-back run
    run_seq({1'b1, 4'd0, 4'd3, 4'd0, 4'd2, 4'd4}, 0, 1, 0);
    // R10: done pulses on idle steps during a long step
    run_seq({1'b1, 4'd0, 4'd0, 4'd9, 4'd0, 4'd0}, 0, 0, 5);

    repeat (3) @(negedge clk);
    chk(!busy && req == '0, "R7 idle after runs", int'({busy, req}), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #800us;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule